// File: doc/BRIEF.md
# Eight-Input Interrupt Controller

This block gathers up to eight interrupt request lines into a single interrupt output for a processor. Each request line is latched on its rising edge into a pending register. A mask register hides chosen lines from the output. While a request is being serviced it is held in an in-service register. When the processor returns an acknowledge strobe, the controller moves the lowest-numbered unmasked pending request into service and presents a vector made from a programmable base plus the request index.

Software talks to the block through two byte-wide locations. Offset 0 is the command location. Offset 1 is the data location. A command with bit 4 set starts a short three-word setup sequence that programs the vector base. Any other command is an operation: it selects what command-location reads return, ends an interrupt in general or for one line, is accepted and ignored, or, if its value is not recognised, sets a sticky error flag. Outside setup, the data location reads and writes the mask.

The bus has one cycle per access. An access presents an address, a write enable and the write data on a clock edge. A cycle with the write enable low is a read, and its data appears on the registered read output after that edge.

Top module: `irq_ctrl8`

## Requirements
- R1: After reset the pending, in-service and mask registers are zero, the interrupt output and error flag are low, the vector output is zero, command-location reads return the poll value, and the vector base equals the BASE_RESET parameter.
- R2: A request line that is low on one clock edge and high on the next sets its pending bit on that second edge. A line that stays high does not set its bit again once the bit has been cleared.
- R3: The interrupt output is high one cycle after the pending register ANDed with the inverted mask is nonzero, and low one cycle after it is zero.
- R4: When no setup sequence is running, a data-location write loads the mask (bit n masks line n), and a data-location read returns the mask.
- R5: A command-location write with bit 4 set starts setup. The next three data-location writes do not touch the mask. The first of them sets the vector base to the written value with bits 2..0 cleared, the second is ignored, and the third ends setup.
- R6: A command-location write with bit 4 clear ends any setup in progress and is decoded as an operation, so the next data-location write loads the mask.
- R7: Command 0x0A makes command-location reads return the pending register, 0x0B makes them return the in-service register, and 0x0C makes them return the poll value.
- R8: The poll value is 0x80 OR the index of the lowest-numbered set pending bit, regardless of the mask, or 0x00 when nothing is pending.
- R9: A cycle with the acknowledge input high and at least one unmasked pending request clears the lowest-numbered such pending bit, sets the same in-service bit, and on the next cycle shows base OR index on the vector output. An acknowledge with nothing eligible changes nothing.
- R10: Command 0x20 clears every pending bit that is also in service, then clears the whole in-service register.
- R11: Commands 0x21 to 0x27, 0x60 to 0x67 and 0xE0 to 0xE7 clear the pending bit and the in-service bit selected by command bits 2..0.
- R12: Commands 0x68 and 0xC0 to 0xC7 change nothing. Any other command with bit 4 clear that is not listed in R7, R10 or R11 sets the error flag, and the flag stays set until reset.
- R13: When a rising request edge and a clear of the same pending bit land on the same edge, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_in | input | 8 | Request lines, latched on a rising edge |
| int_ack | input | 1 | Acknowledge strobe from the processor |
| bus_addr | input | 1 | 0 selects the command location, 1 selects the data location |
| bus_we | input | 1 | Write enable; a cycle with this low is a read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| int_out | output | 1 | Interrupt output to the processor |
| vec_out | output | 8 | Vector of the last acknowledged request |
| err_out | output | 1 | Sticky flag for an unrecognised command |

## Verification
The assertions assume that request lines are synchronous to the clock and that an acknowledge never falls on the same cycle as an end-of-interrupt command. The in-service checks rest on the second assumption. The stimulus changes requests only at the falling edge and always issues acknowledges and bus writes in separate cycles. The one intended overlap, a rising request edge on the same edge as a specific end-of-interrupt, involves no acknowledge, so it stays inside those assumptions.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {RS_PEND, RS_INSVC, RS_POLL} rdsel_t;
  typedef enum logic [1:0] {IS_IDLE, IS_W2, IS_W3, IS_W4} init_t;
endpackage

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irqc_cmd.sv
module irqc_cmd
  import irqc_pkg::*;
#(
  parameter int         DATA_W     = 8,
  parameter int         N          = 8,
  parameter int         IDX_W      = $clog2(N),
  parameter logic [7:0] BASE_RESET = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_cmd,
  input  logic              wr_data,
  input  logic [DATA_W-1:0] wdata,
  output rdsel_t            sel,
  output logic [DATA_W-1:0] base,
  output logic [N-1:0]      mask,
  output logic              err,
  output logic              eoi_all,
  output logic              eoi_one,
  output logic [IDX_W-1:0]  eoi_idx
);
  localparam logic [DATA_W-1:0] ALIGN = ~DATA_W'(N - 1);

  init_t ist;
  logic  op, is_spec, is_nop, is_sel, bad;

  always_comb begin
    op      = wr_cmd && !wdata[4];
    is_spec = (wdata[7:3] == 5'b00100 && wdata[2:0] != 3'd0) ||
              wdata[7:3] == 5'b01100 || wdata[7:3] == 5'b11100;
    is_nop  = wdata == 8'h68 || wdata[7:3] == 5'b11000;
    is_sel  = wdata == 8'h0A || wdata == 8'h0B || wdata == 8'h0C;
    eoi_all = op && wdata == 8'h20;
    eoi_one = op && is_spec;
    eoi_idx = wdata[IDX_W-1:0];
    bad     = op && !is_spec && !is_nop && !is_sel && wdata != 8'h20;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ist  <= IS_IDLE;
      sel  <= RS_POLL;
      base <= BASE_RESET & ALIGN;
      mask <= '0;
      err  <= 1'b0;
    end else begin
      if (wr_cmd) begin
        if (wdata[4]) ist <= IS_W2;
        else          ist <= IS_IDLE;
      end else if (wr_data) begin
        case (ist)
          IS_W2:   begin base <= wdata & ALIGN; ist <= IS_W3; end
          IS_W3:   ist <= IS_W4;
          IS_W4:   ist <= IS_IDLE;
          default: mask <= wdata[N-1:0];
        endcase
      end
      if (op && wdata == 8'h0A) sel <= RS_PEND;
      if (op && wdata == 8'h0B) sel <= RS_INSVC;
      if (op && wdata == 8'h0C) sel <= RS_POLL;
      if (bad) err <= 1'b1;
    end
  end

  a_r12_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
  a_r5_mask_frozen: assert property (@(posedge clk) disable iff (rst)
    (ist != IS_IDLE && !wr_cmd) |=> $stable(mask));
endmodule

// File: rtl/irqc_pend.sv
module irqc_pend #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     irq_in,
  input  logic [N-1:0]     mask,
  input  logic             ack,
  input  logic             eoi_all,
  input  logic             eoi_one,
  input  logic [IDX_W-1:0] eoi_idx,
  output logic [N-1:0]     pend,
  output logic [N-1:0]     isr,
  output logic             ack_hit,
  output logic [IDX_W-1:0] ack_idx
);
  logic [N-1:0] prev, rise, pend_n, isr_n;
  logic         cfound;

  irqc_prio #(.N(N), .IDX_W(IDX_W)) u_pick (
    .req(pend & ~mask), .found(cfound), .idx(ack_idx)
  );

  always_comb begin
    rise    = irq_in & ~prev;
    ack_hit = ack && cfound;
    pend_n  = pend;
    isr_n   = isr;
    if (eoi_all) begin
      pend_n = pend_n & ~isr;
      isr_n  = '0;
    end
    if (eoi_one) begin
      pend_n[eoi_idx] = 1'b0;
      isr_n[eoi_idx]  = 1'b0;
    end
    if (ack_hit) begin
      pend_n[ack_idx] = 1'b0;
      isr_n[ack_idx]  = 1'b1;
    end
    pend_n = pend_n | rise;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= '0;
      pend <= '0;
      isr  <= '0;
    end else begin
      prev <= irq_in;
      pend <= pend_n;
      isr  <= isr_n;
    end
  end

  a_r2_set_needs_edge: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(irq_in & ~prev)) == '0));
  a_r9_ack_adds_one: assert property (@(posedge clk) disable iff (rst)
    (ack_hit && !eoi_all && !eoi_one) |=> $countones(isr) == $countones($past(isr)) + 1);
  a_r10_eoi_empties: assert property (@(posedge clk) disable iff (rst)
    (eoi_all && !ack) |=> isr == '0);
endmodule

// File: rtl/irq_ctrl8.sv
module irq_ctrl8
  import irqc_pkg::*;
#(
  parameter int         DATA_W     = 8,
  parameter int         NUM_IRQ    = 8,
  parameter logic [7:0] BASE_RESET = 8'h00
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               int_ack,
  input  logic               bus_addr,
  input  logic               bus_we,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               int_out,
  output logic [DATA_W-1:0]  vec_out,
  output logic               err_out
);
  localparam int IDX_W = $clog2(NUM_IRQ);
  localparam int PAD_W = DATA_W - 1 - IDX_W;

  rdsel_t              sel;
  logic [DATA_W-1:0]   base, poll_val, cmd_rd;
  logic [NUM_IRQ-1:0]  mask, pend, isr;
  logic                eoi_all, eoi_one, ack_hit, pfound;
  logic [IDX_W-1:0]    eoi_idx, ack_idx, pidx;

  irqc_cmd #(.DATA_W(DATA_W), .N(NUM_IRQ), .IDX_W(IDX_W), .BASE_RESET(BASE_RESET)) u_cmd (
    .clk(clk), .rst(rst),
    .wr_cmd(bus_we && !bus_addr), .wr_data(bus_we && bus_addr), .wdata(bus_wdata),
    .sel(sel), .base(base), .mask(mask), .err(err_out),
    .eoi_all(eoi_all), .eoi_one(eoi_one), .eoi_idx(eoi_idx)
  );

  irqc_pend #(.N(NUM_IRQ), .IDX_W(IDX_W)) u_pend (
    .clk(clk), .rst(rst), .irq_in(irq_in), .mask(mask), .ack(int_ack),
    .eoi_all(eoi_all), .eoi_one(eoi_one), .eoi_idx(eoi_idx),
    .pend(pend), .isr(isr), .ack_hit(ack_hit), .ack_idx(ack_idx)
  );

  irqc_prio #(.N(NUM_IRQ), .IDX_W(IDX_W)) u_poll (
    .req(pend), .found(pfound), .idx(pidx)
  );

  always_comb begin
    poll_val = pfound ? {1'b1, {PAD_W{1'b0}}, pidx} : '0;
    case (sel)
      RS_PEND:  cmd_rd = DATA_W'(pend);
      RS_INSVC: cmd_rd = DATA_W'(isr);
      default:  cmd_rd = poll_val;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      int_out   <= 1'b0;
      vec_out   <= '0;
    end else begin
      bus_rdata <= bus_addr ? DATA_W'(mask) : cmd_rd;
      int_out   <= |(pend & ~mask);
      if (ack_hit) vec_out <= base | DATA_W'(ack_idx);
    end
  end

  a_r3_quiet_when_empty: assert property (@(posedge clk) disable iff (rst)
    (pend == '0) |=> !int_out);
  a_r9_vec_hold: assert property (@(posedge clk) disable iff (rst)
    !ack_hit |=> $stable(vec_out));
endmodule

// File: tb/irq_ctrl8_bench.sv
module irq_ctrl8_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] irq_in = '0;
  logic       int_ack = 1'b0;
  logic       bus_addr = 1'b0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata, vec_out;
  logic       int_out, err_out;

  int errors = 0;
  int checks = 0;
  logic rd_req = 1'b0, rd_q = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  irq_ctrl8 #(.BASE_RESET(8'h08)) u_irq_ctrl8 (
    .clk(clk), .rst(rst), .irq_in(irq_in), .int_ack(int_ack),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .int_out(int_out), .vec_out(vec_out), .err_out(err_out)
  );

  always @(posedge clk) rd_q <= rd_req;

  always @(negedge clk) begin
    if (rd_q && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s: read got %02h expected %02h", t, bus_rdata, e);
      end
    end
  end

  task automatic chk(input string t, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", t, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic a, input logic [7:0] e, input string t);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    exp_q.push_back(e); tag_q.push_back(t);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk);
    int_ack = 1'b1;
    @(negedge clk);
    int_ack = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    join_none
    settle(3);
    rst = 1'b0;
    settle(1);
    // R1: reset state
    chk("R1 int_out", {7'd0, int_out}, 8'h00);
    chk("R1 err_out", {7'd0, err_out}, 8'h00);
    chk("R1 vec_out", vec_out, 8'h00);
    rd(1'b0, 8'h00, "R1 poll empty");
    rd(1'b1, 8'h00, "R1 mask zero");
    // R2 R3 R8: edges, interrupt output, default poll
    irq_in = 8'h28; settle(2);
    chk("R3 int high", {7'd0, int_out}, 8'h01);
    rd(1'b0, 8'h83, "R8 poll lowest");
    wr(1'b0, 8'h0A);
    rd(1'b0, 8'h28, "R7 R2 pending");
    // R4: mask
    wr(1'b1, 8'h08);
    rd(1'b1, 8'h08, "R4 mask read");
    settle(1);
    chk("R3 still high", {7'd0, int_out}, 8'h01);
    wr(1'b0, 8'h0C);
    rd(1'b0, 8'h83, "R8 poll ignores mask");
    wr(1'b0, 8'h0A);
    // R9: acknowledge; R1 base from parameter
    ack();
    chk("R9 R1 vector", vec_out, 8'h0D);
    rd(1'b0, 8'h08, "R9 R2 pending after ack");
    settle(1);
    chk("R3 low when masked", {7'd0, int_out}, 8'h00);
    wr(1'b0, 8'h0B);
    rd(1'b0, 8'h20, "R7 R9 in-service");
    // R11: specific end
    wr(1'b0, 8'h65);
    rd(1'b0, 8'h00, "R11 in-service cleared");
    wr(1'b1, 8'h00);
    ack();
    chk("R9 vector 3", vec_out, 8'h0B);
    irq_in = 8'h00; settle(2);
    irq_in = 8'h28; settle(2);
    // R10: general end
    wr(1'b0, 8'h20);
    rd(1'b0, 8'h00, "R10 in-service empty");
    wr(1'b0, 8'h0A);
    rd(1'b0, 8'h20, "R10 pending in service cleared");
    wr(1'b0, 8'hE5);
    rd(1'b0, 8'h00, "R11 pending cleared");
    ack();
    chk("R9 empty ack keeps vector", vec_out, 8'h0B);
    // R12: ignored and unknown commands
    wr(1'b1, 8'h5A);
    wr(1'b0, 8'h68);
    wr(1'b0, 8'hC3);
    rd(1'b1, 8'h5A, "R12 mask untouched");
    rd(1'b0, 8'h00, "R12 pending untouched");
    chk("R12 no error", {7'd0, err_out}, 8'h00);
    wr(1'b0, 8'h40);
    settle(1);
    chk("R12 error set", {7'd0, err_out}, 8'h01);
    wr(1'b0, 8'h0A);
    settle(1);
    chk("R12 error sticky", {7'd0, err_out}, 8'h01);
    // R5: setup sequence
    wr(1'b0, 8'h11);
    wr(1'b1, 8'h47);
    wr(1'b1, 8'hFF);
    wr(1'b1, 8'h01);
    rd(1'b1, 8'h5A, "R5 mask kept in setup");
    wr(1'b1, 8'h02);
    rd(1'b1, 8'h02, "R5 mask after setup");
    irq_in = 8'h00; settle(2);
    irq_in = 8'h01; settle(2);
    ack();
    chk("R5 new base", vec_out, 8'h40);
    // R6: abort
    wr(1'b0, 8'h13);
    wr(1'b1, 8'h88);
    wr(1'b0, 8'h0A);
    wr(1'b1, 8'h04);
    rd(1'b1, 8'h04, "R6 abort then mask");
    // R13: set wins over same-edge clear
    @(negedge clk);
    irq_in = 8'h03; bus_addr = 1'b0; bus_we = 1'b1; bus_wdata = 8'h21;
    @(negedge clk);
    bus_we = 1'b0;
    rd(1'b0, 8'h02, "R13 edge beats clear");
    wr(1'b0, 8'h0C);
    rd(1'b0, 8'h81, "R7 R8 poll select");
    chk("R3 high before ack", {7'd0, int_out}, 8'h01);
    ack();
    chk("R9 R6 vector", vec_out, 8'h89);
    settle(4);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule